// File: doc/BRIEF.md
# Serial Audio Receiver Control FSM

This block sequences a serial digital audio receiver. Software writes a 2-bit enable field. One nonzero value asks for line synchronization only. Another asks for synchronization followed by data reception. The FSM turns the synchronizer and data capture on and off to match. It latches decoder errors and the sync-done event as sticky flags. When a decoder error arrives, it parks the receiver in a halted state until software writes the enable field back to zero.

Line decoding, preamble detection, FIFOs and the DMA engine sit outside the block and appear here only as handshake signals. When the FSM leaves reception while a DMA transfer is still running, it raises a stop request and holds it until the DMA side reports that it is no longer busy. This lets the running transfer finish cleanly.

Top module: `audio_rx_ctrl`

## Requirements
- R1: After reset, `state_o` is IDLE, all flags are 0, and `sync_en`, `capture_en` and `dma_stop_req` are 0. State codes are IDLE=0, SYNC=1, RCV=2 and STOP=3.
- R2: In IDLE, any nonzero `en_mode` (01, 10 or 11) moves the FSM to SYNC at the next clock edge.
- R3: In SYNC, a high `sync_done` sets `sync_ok` at the next edge. In SYNC with `en_mode`=11 and `sync_ok`=1, the FSM moves to RCV at the next edge.
- R4: In SYNC with `en_mode` 01 or 10, the FSM stays in SYNC even when `sync_ok` is 1.
- R5: In SYNC or RCV, with `en_mode` nonzero, a high `err_frame`, `err_sync` or `err_timeout` moves the FSM to STOP at the next edge. The same edge sets the matching flag (`flag_frame`, `flag_sync` or `flag_timeout`).
- R6: In STOP, the FSM stays in STOP while `en_mode` is nonzero. While it is there, decoder errors and `sync_done` change no flag.
- R7: `en_mode`=0 in SYNC, RCV or STOP returns the FSM to IDLE at the next edge. That edge clears all three error flags and `sync_ok`. A zero enable takes priority over a decoder error arriving in the same cycle.
- R8: `sync_en` is 1 exactly in SYNC and RCV. `capture_en` is 1 only in RCV.
- R9: Leaving RCV while `dma_busy` is 1 raises `dma_stop_req` at the same edge. The request stays high until an edge at which `dma_busy` is 0, and it is never raised when `dma_busy` is 0 on the way out.
- R10: The error flags and `sync_ok` stay set after their input event ends, until the return to IDLE. In IDLE, decoder inputs and `sync_done` set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_mode | input | 2 | Software enable field: 00 off, 01/10 sync only, 11 sync then receive |
| sync_done | input | 1 | Synchronization-complete pulse from the line decoder |
| err_frame | input | 1 | Framing error from the decoder |
| err_sync | input | 1 | Synchronization error from the decoder |
| err_timeout | input | 1 | Timeout error from the decoder |
| dma_busy | input | 1 | DMA transfer in progress |
| state_o | output | 2 | Current state code |
| flag_frame | output | 1 | Sticky framing error flag |
| flag_sync | output | 1 | Sticky synchronization error flag |
| flag_timeout | output | 1 | Sticky timeout error flag |
| sync_ok | output | 1 | Sticky sync-done status |
| sync_en | output | 1 | Synchronizer enable |
| capture_en | output | 1 | Data capture enable |
| dma_stop_req | output | 1 | Request to the DMA interface to stop after the current transfer |

## Verification
The assertions check the following transition rules on every cycle:
- IDLE leaves on any nonzero enable.
- An error in SYNC or RCV lands in STOP.
- STOP holds while the enable is nonzero.
- A zero enable reaches IDLE.
- The sync-only codes never reach RCV.
- IDLE always shows cleared flags.
- A pending DMA stop request persists while the DMA side is busy.

Only the bench scenarios show which flag records which error and that errors in STOP leave the flags untouched. They also show the exact cycle in which the stop request appears and drops, and that a zero enable wins over a simultaneous error.

// File: rtl/audio_rx_ctrl.sv
`timescale 1ns/1ps
module audio_rx_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_mode,
  input  logic       sync_done,
  input  logic       err_frame,
  input  logic       err_sync,
  input  logic       err_timeout,
  input  logic       dma_busy,
  output logic [1:0] state_o,
  output logic       flag_frame,
  output logic       flag_sync,
  output logic       flag_timeout,
  output logic       sync_ok,
  output logic       sync_en,
  output logic       capture_en,
  output logic       dma_stop_req
);
  localparam logic [1:0] S_IDLE = 2'd0, S_SYNC = 2'd1, S_RCV = 2'd2, S_STOP = 2'd3;

  logic [1:0] st, nxt;
  logic       any_err, active, off, go_idle;

  assign any_err = err_frame | err_sync | err_timeout;
  assign active  = (st == S_SYNC) || (st == S_RCV);
  assign off     = (en_mode == 2'b00);
  assign go_idle = (nxt == S_IDLE);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (!off) nxt = S_SYNC;
      S_SYNC: if (off) nxt = S_IDLE;
              else if (any_err) nxt = S_STOP;
              else if (en_mode == 2'b11 && sync_ok) nxt = S_RCV;
      S_RCV:  if (off) nxt = S_IDLE;
              else if (any_err) nxt = S_STOP;
      S_STOP: if (off) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      flag_frame   <= 1'b0;
      flag_sync    <= 1'b0;
      flag_timeout <= 1'b0;
      sync_ok      <= 1'b0;
      dma_stop_req <= 1'b0;
    end else begin
      st <= nxt;
      if (go_idle) begin
        flag_frame   <= 1'b0;
        flag_sync    <= 1'b0;
        flag_timeout <= 1'b0;
        sync_ok      <= 1'b0;
      end else if (active) begin
        flag_frame   <= flag_frame   | err_frame;
        flag_sync    <= flag_sync    | err_sync;
        flag_timeout <= flag_timeout | err_timeout;
        if (st == S_SYNC) sync_ok <= sync_ok | sync_done;
      end
      if (dma_stop_req) dma_stop_req <= dma_busy;
      else dma_stop_req <= (st == S_RCV) && (nxt != S_RCV) && dma_busy;
    end
  end

  assign state_o    = st;
  assign sync_en    = active;
  assign capture_en = (st == S_RCV);

  p_idle_leaves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_IDLE && en_mode != 2'b00) |=> state_o == S_SYNC);
  p_sync_only_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_SYNC && (en_mode == 2'b01 || en_mode == 2'b10)) |=> state_o != S_RCV);
  p_err_to_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == S_SYNC || state_o == S_RCV) && en_mode != 2'b00 &&
     (err_frame || err_sync || err_timeout)) |=> state_o == S_STOP);
  p_stop_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_STOP && en_mode != 2'b00) |=> state_o == S_STOP);
  p_off_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != S_IDLE && en_mode == 2'b00) |=> state_o == S_IDLE);
  p_idle_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_IDLE) |-> !(flag_frame || flag_sync || flag_timeout || sync_ok));
  p_stopreq_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stop_req && dma_busy) |=> dma_stop_req);
  p_capture_rcv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> (sync_en && state_o == S_RCV));
endmodule

// File: tb/audio_rx_ctrl_test.sv
`timescale 1ns/1ps
module audio_rx_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] en_mode = 2'b00;
  logic sync_done = 0, err_frame = 0, err_sync = 0, err_timeout = 0, dma_busy = 0;
  logic [1:0] state_o;
  logic flag_frame, flag_sync, flag_timeout, sync_ok, sync_en, capture_en, dma_stop_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_rx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en_mode(en_mode), .sync_done(sync_done),
    .err_frame(err_frame), .err_sync(err_sync), .err_timeout(err_timeout),
    .dma_busy(dma_busy), .state_o(state_o), .flag_frame(flag_frame),
    .flag_sync(flag_sync), .flag_timeout(flag_timeout), .sync_ok(sync_ok),
    .sync_en(sync_en), .capture_en(capture_en), .dma_stop_req(dma_stop_req));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [8:0] exp_q[$];
  string tag_q[$];

  localparam logic [1:0] I = 0, S = 1, R = 2, P = 3;

  function automatic logic [8:0] mk(logic [1:0] st, logic [2:0] fl, logic sok,
                                    logic sen, logic cen, logic dreq);
    return {st, fl, sok, sen, cen, dreq};
  endfunction

  function automatic logic [8:0] act();
    return {state_o, flag_frame, flag_sync, flag_timeout, sync_ok, sync_en, capture_en, dma_stop_req};
  endfunction

  task automatic check(logic [8:0] e, string tag);
    logic [8:0] a = act();
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b (st,ff,fs,ft,sok,sen,cen,dreq)", tag, a, e);
    end
  endtask

  task automatic step(logic [1:0] en, logic sd, logic ef, logic es, logic et,
                      logic bz, logic [8:0] e, string tag);
    @(negedge clk);
    en_mode = en; sync_done = sd; err_frame = ef; err_sync = es; err_timeout = et; dma_busy = bz;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(mk(I, 3'b000, 0, 0, 0, 0), "R1 reset");
    rst_n = 1'b1;
    step(2'b00, 0,0,0,0,0, mk(I,3'b000,0,0,0,0), "R1 idle after reset");
    step(2'b01, 0,0,0,0,0, mk(S,3'b000,0,1,0,0), "R2 idle->sync on 01");
    step(2'b01, 1,0,0,0,0, mk(S,3'b000,1,1,0,0), "R3 sync_ok set");
    step(2'b01, 0,0,0,0,0, mk(S,3'b000,1,1,0,0), "R4 01 stays in sync");
    step(2'b10, 0,0,0,0,0, mk(S,3'b000,1,1,0,0), "R4 10 stays in sync");
    step(2'b11, 0,0,0,0,0, mk(R,3'b000,1,1,1,0), "R3 sync->rcv");
    step(2'b11, 0,0,0,0,1, mk(R,3'b000,1,1,1,0), "R8 rcv enables");
    step(2'b11, 0,1,0,0,1, mk(P,3'b100,1,0,0,1), "R5 R9 frame err to stop, dma req");
    step(2'b11, 0,0,0,0,1, mk(P,3'b100,1,0,0,1), "R6 R10 stop holds, req held");
    step(2'b11, 1,0,1,1,1, mk(P,3'b100,1,0,0,1), "R6 errors ignored in stop");
    step(2'b11, 0,0,0,0,0, mk(P,3'b100,1,0,0,0), "R9 req drops when not busy");
    step(2'b00, 0,0,0,0,0, mk(I,3'b000,0,0,0,0), "R7 stop->idle clears");
    step(2'b11, 0,0,0,0,0, mk(S,3'b000,0,1,0,0), "R2 idle->sync on 11");
    step(2'b11, 0,0,0,1,0, mk(P,3'b001,0,0,0,0), "R5 timeout in sync");
    step(2'b00, 0,0,0,0,0, mk(I,3'b000,0,0,0,0), "R7 clear timeout flag");
    step(2'b10, 0,0,0,0,0, mk(S,3'b000,0,1,0,0), "R2 idle->sync on 10");
    step(2'b00, 0,0,1,0,0, mk(I,3'b000,0,0,0,0), "R7 disable beats error");
    step(2'b11, 0,0,0,0,0, mk(S,3'b000,0,1,0,0), "R2 reenter sync");
    step(2'b11, 1,0,0,0,0, mk(S,3'b000,1,1,0,0), "R3 sync_ok before rcv");
    step(2'b11, 0,0,0,0,0, mk(R,3'b000,1,1,1,0), "R3 rcv again");
    step(2'b00, 0,0,0,0,1, mk(I,3'b000,0,0,0,1), "R7 R9 rcv->idle with busy");
    step(2'b00, 0,0,0,0,1, mk(I,3'b000,0,0,0,1), "R9 req held while busy");
    step(2'b00, 0,0,0,0,0, mk(I,3'b000,0,0,0,0), "R9 req released");
    step(2'b11, 0,0,0,0,0, mk(S,3'b000,0,1,0,0), "R2 sync");
    step(2'b11, 1,0,0,0,0, mk(S,3'b000,1,1,0,0), "R3 sync_ok");
    step(2'b11, 0,0,0,0,0, mk(R,3'b000,1,1,1,0), "R8 rcv");
    step(2'b11, 0,0,1,0,0, mk(P,3'b010,1,0,0,0), "R5 R9 sync err, no req when idle dma");
    step(2'b00, 0,0,0,0,0, mk(I,3'b000,0,0,0,0), "R7 back to idle");
    step(2'b00, 1,1,1,1,0, mk(I,3'b000,0,0,0,0), "R10 idle ignores decoder");
    step(2'b00, 0,0,0,0,0, mk(I,3'b000,0,0,0,0), "R10 idle still clean");
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule